// File: doc/BRIEF.md
# I2C Slave Address Mask Comparator

This block sits in the receive path of an I2C target. It holds a programmable own address and a per-bit compare mask. After a START or a repeated START, the first byte that the shift logic presents is compared against the own address. Only the bit positions whose mask bit is 1 take part in the comparison. The result is held as a match flag until the bus signals the next START, repeated START or STOP.

On a match, the block also keeps the direction bit of that byte. It raises a separate flag when the byte carries the 10-bit header pattern. For a 10-bit target, the own address register is programmed with that header, so only the two upper address bits are compared here. The second address byte and all acknowledge and data handling belong to the surrounding logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `own_addr` reads 0x00, `addr_mask` reads 0xFE, and `match`, `dir_read` and `hdr10` are 0.
- R2: A write to either register stores bits 7:1 of the write data. Bit 0 always reads back as 0, whatever value was written to it, and the new value is visible on the cycle after the write.
- R3: When the compared bits of the received byte all equal the own address, `match` is 1 on the cycle after the strobe.
- R4: A received bit 7:1 whose mask bit is 0 has no effect on the comparison.
- R5: A difference in any received bit 7:1 whose mask bit is 1 gives `match` = 0.
- R6: On a match, `dir_read` takes bit 0 of the received byte (1 = read). A byte that does not match leaves `dir_read` unchanged.
- R7: `hdr10` is 1 after a first byte whose bits 7:3 are 11110, whether or not that byte matched. Otherwise it is 0.
- R8: Only the first strobe after a START or repeated START is evaluated. Later strobes leave `match`, `dir_read` and `hdr10` unchanged.
- R9: `bus_start` or `bus_stop` clears `match` and `hdr10` on the next cycle.
- R10: A strobe after a STOP, with no START since, is ignored.
- R11: When `bus_start` and `rx_valid` are both high in the same cycle, the START wins. The byte is not evaluated, and the next strobe is the one that gets compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse for START or repeated START |
| bus_stop | input | 1 | One-cycle pulse for STOP |
| rx_valid | input | 1 | Strobe: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte: address in bits 7:1, direction in bit 0 |
| addr_we | input | 1 | Write enable for the own address register |
| addr_wdata | input | 8 | Own address write data |
| mask_we | input | 1 | Write enable for the mask register |
| mask_wdata | input | 8 | Mask write data |
| own_addr | output | 8 | Own address readback, bit 0 always 0 |
| addr_mask | output | 8 | Mask readback, bit 0 always 0 |
| match | output | 1 | The first byte after START matched |
| dir_read | output | 1 | Direction bit from the last matching byte |
| hdr10 | output | 1 | The first byte carried the 10-bit header pattern |

## Verification
A wrong armed state is visible at the ports on the cycle after the next strobe. If the block failed to arm, a matching first byte would leave `match` low. If it failed to disarm, a second byte would overwrite `match` or `dir_read`. A corrupted register or mask bit changes the outcome of the first compare that uses that bit position, and it also shows directly on the readback ports one cycle after the write. Stale flags that survive a START or STOP are visible one cycle after that bus event.

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match #(
  parameter int AW = 7,
  parameter logic [AW-1:0] ADDR_RST = '0,
  parameter logic [AW-1:0] MASK_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          rx_valid,
  input  logic [AW:0]   rx_byte,
  input  logic          addr_we,
  input  logic [AW:0]   addr_wdata,
  input  logic          mask_we,
  input  logic [AW:0]   mask_wdata,
  output logic [AW:0]   own_addr,
  output logic [AW:0]   addr_mask,
  output logic          match,
  output logic          dir_read,
  output logic          hdr10
);
  localparam int BW = AW + 1;

  logic [AW-1:0] addr_q, mask_q;
  logic          armed;

  assign own_addr  = {addr_q, 1'b0};
  assign addr_mask = {mask_q, 1'b0};

  wire hit  = ((rx_byte[BW-1:1] ^ addr_q) & mask_q) == '0;
  wire hdr  = rx_byte[BW-1 -: 5] == 5'b11110;
  wire take = rx_valid & armed & ~bus_start & ~bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= ADDR_RST;
      mask_q <= MASK_RST;
    end else begin
      if (addr_we) addr_q <= addr_wdata[BW-1:1];
      if (mask_we) mask_q <= mask_wdata[BW-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      match    <= 1'b0;
      dir_read <= 1'b0;
      hdr10    <= 1'b0;
    end else if (bus_start || bus_stop) begin
      armed <= bus_start;
      match <= 1'b0;
      hdr10 <= 1'b0;
    end else if (take) begin
      armed <= 1'b0;
      match <= hit;
      hdr10 <= hdr;
      if (hit) dir_read <= rx_byte[0];
    end
  end
endmodule

module i2c_addr_match_chk #(parameter int AW = 7) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_start,
  input logic        bus_stop,
  input logic        rx_valid,
  input logic        addr_we,
  input logic [AW:0] addr_wdata,
  input logic        mask_we,
  input logic [AW:0] mask_wdata,
  input logic [AW:0] own_addr,
  input logic [AW:0] addr_mask,
  input logic        match,
  input logic        dir_read,
  input logic        hdr10
);
  p_addr_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> own_addr == {$past(addr_wdata[AW:1]), 1'b0});
  p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> addr_mask == {$past(mask_wdata[AW:1]), 1'b0});
  p_rise_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) |-> $past(rx_valid));
  p_dir_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_read) |-> match);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !bus_start && !bus_stop) |=>
      ($stable(match) && $stable(hdr10) && $stable(dir_read)));
  p_bus_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> (!match && !hdr10));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .rx_valid(rx_valid), .addr_we(addr_we), .addr_wdata(addr_wdata),
  .mask_we(mask_we), .mask_wdata(mask_wdata), .own_addr(own_addr),
  .addr_mask(addr_mask), .match(match), .dir_read(dir_read), .hdr10(hdr10)
);

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, addr_we = 0, mask_we = 0;
  logic [7:0] rx_byte = 0, addr_wdata = 0, mask_wdata = 0;
  logic [7:0] own_addr, addr_mask;
  logic match, dir_read, hdr10;

  always #2.5 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .addr_we(addr_we),
    .addr_wdata(addr_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .own_addr(own_addr), .addr_mask(addr_mask), .match(match),
    .dir_read(dir_read), .hdr10(hdr10)
  );

  typedef struct {
    int         at;
    logic [7:0] a, k;
    logic       m, d, h;
    string      req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] ma = 8'h00, mk = 8'hFE;
  logic mm = 0, md = 0, mh = 0, marm = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (own_addr !== e.a || addr_mask !== e.k || match !== e.m ||
          dir_read !== e.d || hdr10 !== e.h) begin
        errors++;
        $display("FAIL %s: got addr=%h mask=%h m=%b d=%b h=%b, expected addr=%h mask=%h m=%b d=%b h=%b",
                 e.req, own_addr, addr_mask, match, dir_read, hdr10,
                 e.a, e.k, e.m, e.d, e.h);
      end
    end
  end

  task automatic step(input logic st, input logic sp, input logic v,
                      input logic [7:0] b, input logic awe, input logic [7:0] ad,
                      input logic mwe, input logic [7:0] mdat, input string req);
    logic cmp;
    exp_t e;
    @(negedge clk);
    bus_start = st; bus_stop = sp; rx_valid = v; rx_byte = b;
    addr_we = awe; addr_wdata = ad; mask_we = mwe; mask_wdata = mdat;
    cmp = ((b[7:1] ^ ma[7:1]) & mk[7:1]) == 7'd0;
    if (st) begin mm = 0; mh = 0; marm = 1; end
    else if (sp) begin mm = 0; mh = 0; marm = 0; end
    else if (v && marm) begin
      mm = cmp; mh = (b[7:3] == 5'b11110); marm = 0;
      if (cmp) md = b[0];
    end
    if (awe) ma = {ad[7:1], 1'b0};
    if (mwe) mk = {mdat[7:1], 1'b0};
    e.at = cyc + 1; e.a = ma; e.k = mk; e.m = mm; e.d = md; e.h = mh; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    step(0, 0, 0, 8'h00, 1, 8'h55, 1, 8'hFF, "R2 write forces bit0");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 start");
    step(0, 0, 1, 8'h55, 0, 8'h00, 0, 8'h00, "R3 match read dir R6");
    step(0, 0, 1, 8'h00, 0, 8'h00, 0, 8'h00, "R8 second byte ignored");
    step(0, 1, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 stop clears");
    step(0, 0, 1, 8'h55, 0, 8'h00, 0, 8'h00, "R10 strobe after stop");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 start");
    step(0, 0, 1, 8'h56, 0, 8'h00, 0, 8'h00, "R5 masked mismatch R6 dir held");
    step(0, 0, 0, 8'h00, 0, 8'h00, 1, 8'hFD, "R2 mask write");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 repeated start");
    step(0, 0, 1, 8'h56, 0, 8'h00, 0, 8'h00, "R4 don't-care bit, dir write");
    step(0, 0, 0, 8'h00, 1, 8'hF6, 1, 8'hFE, "R2 10-bit header address");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 start clears");
    step(0, 0, 1, 8'hF7, 0, 8'h00, 0, 8'h00, "R7 header match");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 repeated start clears hdr10");
    step(0, 0, 1, 8'hF2, 0, 8'h00, 0, 8'h00, "R7 header without match");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 start");
    step(0, 0, 1, 8'h24, 0, 8'h00, 0, 8'h00, "R7 no header");
    step(1, 0, 1, 8'hF7, 0, 8'h00, 0, 8'h00, "R11 start wins over strobe");
    step(0, 0, 1, 8'hF7, 0, 8'h00, 0, 8'h00, "R11 next strobe compared");
    step(0, 0, 1, 8'hF6, 0, 8'h00, 0, 8'h00, "R8 later strobe ignored");
    idle("R8 idle hold");
    idle("R8 idle hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule